// File: doc/BRIEF.md
# Dual-Plane Flash Status Responder

This block produces what a host sees on the read data bus of a two-plane NOR flash while an embedded program or erase is running. A command decoder hands it strobes that start a program, a sector erase or a whole-array erase. It also receives strobes that suspend or resume an erase. A cycle timer tells it, plane by plane, when the internal operation has finished. On every read the block decides whether to pass the array word through untouched or to replace it with a status word. That word carries a data-polling bit, a busy toggle bit and a suspended-sector toggle bit. An active-low ready/busy output covers both planes.

Each plane keeps its own busy state and its own toggle bit. The host can therefore poll one plane while it reads real data from the other. A single erase record holds the sector being erased and whether it is running, draining into suspension or suspended. Suspension takes effect a fixed number of clock cycles after the request. Once suspended, the erased plane is free for reads and programs outside the suspended sector.

Top module: `flash_status_resp`

## Requirements
- R1: The sector number is `op_sector_i`/`rd_sector_i` (upper address bits). Its two most significant bits select the plane: 00 selects plane 0 and any other value selects plane 1. Read data appears on `rd_data_o` one clock after `rd_i` and holds until the next read. A read from a plane that is neither busy nor hitting a suspended sector returns `array_data_i` unchanged.
- R2: A substituted status word is zero in every bit except bit 7 (polling), bit 6 (busy toggle) and bit 2 (suspend toggle).
- R3: `op_kind_i` encodes 01 program, 10 sector erase, 11 whole-array erase, and 00 is ignored. While a plane is programming, any read of that plane returns bit 7 as the complement of `poll_bit_i` as loaded at the start.
- R4: While a plane is erasing, reads of that plane return bit 7 as 0.
- R5: Bit 6 is 0 on the first read of a busy plane after an operation starts, and inverts on each further read of that plane. Reads of the other plane do not change it.
- R6: When `done_i` pulses for a busy plane, that plane returns to idle. Subsequent reads of it return array data.
- R7: `rdy_busy_no` is 0 exactly while at least one plane is programming or erasing, including while a suspend is pending. It is 1 otherwise.
- R8: A suspend strobe while an erase runs takes effect `SUSP_CYC` clocks after the strobe. Until then the erase stays busy; afterwards its plane is idle. A suspend strobe with no running erase has no effect.
- R9: A read of the suspended sector returns bit 7 = 1 when its plane is idle, bit 6 = 0, and bit 2 toggling from 0 on each such read. A program aimed at the suspended sector is rejected.
- R10: An erase start is rejected while any erase is running or suspended. Any start is rejected on a busy plane. A start in the same cycle as a suspend or resume strobe is rejected.
- R11: A resume is accepted only when its `op_sector_i` selects the suspended plane and that plane is idle. It makes the plane busy erasing again with its toggle state kept.
- R12: A whole-array erase makes both planes busy. A suspend marks every sector of both planes as suspended. Resume accepts either plane's address, and a `done_i` pulse on either plane ends the erase on both.
- R13: During a suspension a program to another sector is accepted. While it runs, reads of the suspended sector show the polling and toggle bits of the program together with the suspend toggle.
- R14: A read in the same cycle as a `done_i` pulse reports the status before completion. A `done_i` pulse in the cycle the suspend would take effect ends the erase, and no suspension follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_start_i | input | 1 | Start strobe for the operation in `op_kind_i` |
| op_kind_i | input | 2 | Operation code: 01 program, 10 sector erase, 11 whole-array erase |
| op_sector_i | input | SECT_W | Sector of a start, or plane address of a resume |
| poll_bit_i | input | 1 | Bit 7 of the word being programmed |
| suspend_i | input | 1 | Erase suspend strobe (no address) |
| resume_i | input | 1 | Erase resume strobe |
| done_i | input | 2 | Per-plane completion strobe from the cycle timer |
| rd_i | input | 1 | Read strobe |
| rd_sector_i | input | SECT_W | Sector of the read |
| array_data_i | input | DATA_W | Array word for the read address |
| rd_data_o | output | DATA_W | Read data, registered |
| rdy_busy_no | output | 1 | Ready/busy, low while busy |

## Verification
Two pairs of events can land in the same cycle. A completion pulse can coincide with a read of the finishing plane. A completion pulse can also coincide with the clock edge on which a pending suspend would take hold. The bench drives both pairs on the same clock edge. The first pair is judged by the read returning the pre-completion status word. The second is judged by the erase ending outright: ready/busy rises, the sector reads back true data, and a fresh erase is accepted. A behavioural reference model, updated on every edge, also compares both outputs on every cycle of the run.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int NPLANE   = 2;
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int STOG_BIT = 2;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_SERASE = 2'd2,
    OP_CERASE = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    PL_IDLE  = 2'd0,
    PL_PROG  = 2'd1,
    PL_ERASE = 2'd2
  } pl_state_e;

  // two top address bits: 00 -> plane 0, else plane 1
  function automatic logic plane_of(input logic [1:0] hi);
    return hi != 2'b00;
  endfunction
endpackage

// File: rtl/flash_plane_track.sv
module flash_plane_track
  import flash_stat_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_prog_i,
  input  logic      start_erase_i,
  input  logic      poll_bit_i,
  input  logic      done_i,
  input  logic      susp_i,
  input  logic      resume_i,
  input  logic      rd_hit_i,
  output pl_state_e state_o,
  output logic      poll_o,
  output logic      tog_o
);

  logic start;
  assign start = start_prog_i | start_erase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= PL_IDLE;
      poll_o  <= 1'b0;
      tog_o   <= 1'b0;
    end else begin
      if (done_i && state_o != PL_IDLE) begin
        state_o <= PL_IDLE;
      end else if (susp_i) begin
        state_o <= PL_IDLE;
      end else if (resume_i) begin
        state_o <= PL_ERASE;
      end else if (start_prog_i) begin
        state_o <= PL_PROG;
        poll_o  <= poll_bit_i;
      end else if (start_erase_i) begin
        state_o <= PL_ERASE;
      end

      if (start) begin
        tog_o <= 1'b0;
      end else if (rd_hit_i && state_o != PL_IDLE) begin
        tog_o <= ~tog_o;
      end
    end
  end

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_stat_pkg::*;
#(
  parameter int SECT_W   = 5,
  parameter int SUSP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              chip_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic [NPLANE-1:0] done_i,
  input  logic              rd_hit_i,
  output logic              act_o,
  output logic              run_o,
  output logic              susp_o,
  output logic              pend_o,
  output logic              chip_o,
  output logic [SECT_W-1:0] sector_o,
  output logic              fire_o,
  output logic              tog2_o
);

  localparam int CNT_W = (SUSP_CYC > 1) ? $clog2(SUSP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SUSP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             own_pl;
  logic             ers_done;

  assign own_pl   = plane_of(sector_o[SECT_W-1 -: 2]);
  assign run_o    = act_o & ~susp_o;
  assign ers_done = run_o & (chip_o ? (|done_i) : done_i[own_pl]);
  assign fire_o   = pend_o & (cnt_q == '0) & ~ers_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o    <= 1'b0;
      susp_o   <= 1'b0;
      pend_o   <= 1'b0;
      chip_o   <= 1'b0;
      sector_o <= '0;
      cnt_q    <= '0;
    end else if (ers_done) begin
      act_o  <= 1'b0;
      pend_o <= 1'b0;
      susp_o <= 1'b0;
    end else begin
      if (go_i) begin
        act_o    <= 1'b1;
        chip_o   <= chip_i;
        sector_o <= sector_i;
      end
      if (suspend_i && act_o && !susp_o && !pend_o) begin
        pend_o <= 1'b1;
        cnt_q  <= CNT_INIT;
      end else if (pend_o) begin
        if (cnt_q == '0) begin
          pend_o <= 1'b0;
          susp_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (resume_i) susp_o <= 1'b0;
    end
  end

  // suspend toggle: cleared on entry, flips per suspended-sector read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tog2_o <= 1'b0;
    else if (fire_o)   tog2_o <= 1'b0;
    else if (rd_hit_i) tog2_o <= ~tog2_o;
  end

endmodule

// File: rtl/flash_status_fmt.sv
module flash_status_fmt
  import flash_stat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  pl_state_e          state_i,
  input  logic               poll_i,
  input  logic               tog_i,
  input  logic               sus_hit_i,
  input  logic               tog2_i,
  input  logic [DATA_W-1:0]  array_i,
  output logic [DATA_W-1:0]  word_o
);

  always_comb begin
    word_o = array_i;
    if (state_i != PL_IDLE || sus_hit_i) begin
      word_o           = '0;
      word_o[POLL_BIT] = (state_i == PL_IDLE) ? 1'b1 :
                         (state_i == PL_PROG) ? ~poll_i : 1'b0;
      word_o[TOG_BIT]  = (state_i != PL_IDLE) & tog_i;
      word_o[STOG_BIT] = sus_hit_i & tog2_i;
    end
  end

endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_stat_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SECT_W   = 5,
  parameter int SUSP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_start_i,
  input  logic [1:0]        op_kind_i,
  input  logic [SECT_W-1:0] op_sector_i,
  input  logic              poll_bit_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic [1:0]        done_i,
  input  logic              rd_i,
  input  logic [SECT_W-1:0] rd_sector_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rdy_busy_no
);

  pl_state_e         pl_st   [NPLANE];
  logic              pl_poll [NPLANE];
  logic              pl_tog  [NPLANE];
  logic [NPLANE-1:0] pl_busy;
  logic [NPLANE-1:0] pl_done;

  logic              ers_act, ers_run, ers_susp, ers_pend, ers_chip, ers_fire, ers_tog2;
  logic [SECT_W-1:0] ers_sector;
  logic              ers_pl;

  logic              op_pl, rd_pl, cmd_ok, both_idle, op_pl_idle;
  logic              op_sus_hit, rd_sus_hit;
  logic              prog_go, serase_go, cerase_go, resume_go;
  logic [DATA_W-1:0] fmt_word;
  op_kind_e          kind;

  assign kind      = op_kind_e'(op_kind_i);
  assign op_pl     = plane_of(op_sector_i[SECT_W-1 -: 2]);
  assign rd_pl     = plane_of(rd_sector_i[SECT_W-1 -: 2]);
  assign ers_pl    = plane_of(ers_sector[SECT_W-1 -: 2]);
  assign both_idle = ~|pl_busy;
  assign op_pl_idle = ~pl_busy[op_pl];

  assign op_sus_hit = ers_susp & (ers_chip | (op_sector_i == ers_sector));
  assign rd_sus_hit = ers_susp & (ers_chip | (rd_sector_i == ers_sector));

  // starts collide with suspend/resume: drop the start
  assign cmd_ok    = op_start_i & ~suspend_i & ~resume_i;
  assign prog_go   = cmd_ok & (kind == OP_PROG) & op_pl_idle & ~op_sus_hit;
  assign serase_go = cmd_ok & (kind == OP_SERASE) & ~ers_act & op_pl_idle;
  assign cerase_go = cmd_ok & (kind == OP_CERASE) & ~ers_act & both_idle;
  assign resume_go = resume_i & ers_susp &
                     (ers_chip ? both_idle : ((op_pl == ers_pl) & ~pl_busy[ers_pl]));

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    localparam logic PID = 1'(p);
    logic touch;
    assign touch      = ers_chip | (ers_pl == PID);
    assign pl_busy[p] = (pl_st[p] != PL_IDLE);
    assign pl_done[p] = done_i[p] | (ers_chip & ers_run & (|done_i));

    flash_plane_track u_track (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_prog_i (prog_go & (op_pl == PID)),
      .start_erase_i((serase_go & (op_pl == PID)) | cerase_go),
      .poll_bit_i   (poll_bit_i),
      .done_i       (pl_done[p]),
      .susp_i       (ers_fire & touch),
      .resume_i     (resume_go & touch),
      .rd_hit_i     (rd_i & (rd_pl == PID)),
      .state_o      (pl_st[p]),
      .poll_o       (pl_poll[p]),
      .tog_o        (pl_tog[p])
    );
  end

  flash_erase_ctrl #(
    .SECT_W  (SECT_W),
    .SUSP_CYC(SUSP_CYC)
  ) u_erase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (serase_go | cerase_go),
    .chip_i   (cerase_go),
    .sector_i (op_sector_i),
    .suspend_i(suspend_i),
    .resume_i (resume_go),
    .done_i   (done_i),
    .rd_hit_i (rd_i & rd_sus_hit),
    .act_o    (ers_act),
    .run_o    (ers_run),
    .susp_o   (ers_susp),
    .pend_o   (ers_pend),
    .chip_o   (ers_chip),
    .sector_o (ers_sector),
    .fire_o   (ers_fire),
    .tog2_o   (ers_tog2)
  );

  flash_status_fmt #(.DATA_W(DATA_W)) u_fmt (
    .state_i  (pl_st[rd_pl]),
    .poll_i   (pl_poll[rd_pl]),
    .tog_i    (pl_tog[rd_pl]),
    .sus_hit_i(rd_sus_hit),
    .tog2_i   (ers_tog2),
    .array_i  (array_data_i),
    .word_o   (fmt_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= fmt_word;
  end

  assign rdy_busy_no = both_idle;

endmodule

// File: rtl/flash_status_resp_chk.sv
module flash_status_resp_chk #(
  parameter int DATA_W   = 16,
  parameter int SUSP_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_start_i,
  input logic              resume_i,
  input logic [1:0]        done_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rdy_busy_no,
  input logic              ers_susp_i,
  input logic              ers_pend_i
);

  logic seen_q;
  int   pend_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      pend_len <= 0;
    end else begin
      seen_q   <= 1'b1;
      pend_len <= ers_pend_i ? pend_len + 1 : 0;
    end
  end

  // R7
  busy_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $fell(rdy_busy_no) |-> $past(op_start_i | resume_i));

  // R6
  busy_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $rose(rdy_busy_no) |-> $past((|done_i) | ers_pend_i));

  // R1
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(rd_i & rdy_busy_no & ~ers_susp_i) |-> rd_data_o == $past(array_data_i));

  // R8
  susp_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $rose(ers_susp_i) |-> $past(ers_pend_i));

  // R8
  susp_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_pend_i |-> pend_len < SUSP_CYC);

endmodule

bind flash_status_resp flash_status_resp_chk #(
  .DATA_W  (DATA_W),
  .SUSP_CYC(SUSP_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_start_i  (op_start_i),
  .resume_i    (resume_i),
  .done_i      (done_i),
  .rd_i        (rd_i),
  .array_data_i(array_data_i),
  .rd_data_o   (rd_data_o),
  .rdy_busy_no (rdy_busy_no),
  .ers_susp_i  (ers_susp),
  .ers_pend_i  (ers_pend)
);

// File: tb/tb_flash_status_resp.sv
module tb_flash_status_resp;
  localparam int CLK_PERIOD = 10;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [19:0] op_addr = '0;
  logic        poll_bit = 1'b0;
  logic        suspend = 1'b0;
  logic        resume = 1'b0;
  logic [1:0]  done = 2'd0;
  logic        rd = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [15:0] array_data;
  logic [15:0] rd_data;
  logic        rdy_n;

  assign array_data = rd_addr[15:0] ^ 16'h5AC3;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_resp #(.DATA_W(16), .SECT_W(5), .SUSP_CYC(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .op_start_i(op_start), .op_kind_i(op_kind),
    .op_sector_i(op_addr[19:15]), .poll_bit_i(poll_bit), .suspend_i(suspend),
    .resume_i(resume), .done_i(done), .rd_i(rd), .rd_sector_i(rd_addr[19:15]),
    .array_data_i(array_data), .rd_data_o(rd_data), .rdy_busy_no(rdy_n)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R7";
  bit    finished = 0;

  // reference model
  int          m_kind [2];
  bit          m_pd   [2];
  bit          m_t6   [2];
  bit          m_act, m_chip, m_susp, m_pend, m_t2;
  int          m_cnt, m_sec, m_pl;
  logic [15:0] m_rd;

  function automatic int pl(input logic [19:0] a);
    return (a[19:18] == 2'b00) ? 0 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < 2; q++) begin m_kind[q] = 0; m_pd[q] = 0; m_t6[q] = 0; end
      m_act = 0; m_chip = 0; m_susp = 0; m_pend = 0; m_t2 = 0;
      m_cnt = 0; m_sec = 0; m_pl = 0; m_rd = '0;
    end else begin
      int  rp, op, nk[2];
      bit  hit, f6, f2, run, edone, fire, ok, gp, gs, gc, res, tch, nt6[2];
      logic [15:0] w;
      rp  = pl(rd_addr);
      op  = pl(op_addr);
      hit = m_susp && (m_chip || int'(rd_addr[19:15]) == m_sec);
      f6 = 0; f2 = 0;
      if (rd) begin
        if (m_kind[rp] == 0 && !hit) w = array_data;
        else begin
          w = '0;
          if (m_kind[rp] != 0) begin
            w[7] = (m_kind[rp] == 1) ? ~m_pd[rp] : 1'b0;
            w[6] = m_t6[rp];
            f6 = 1;
          end else w[7] = 1'b1;
          if (hit) begin w[2] = m_t2; f2 = 1; end
        end
        m_rd = w;
      end
      run   = m_act && !m_susp;
      edone = run && (m_chip ? (done != 0) : done[m_pl]);
      fire  = m_pend && m_cnt == 0 && !edone;
      ok  = op_start && !suspend && !resume;
      gp  = ok && op_kind == 1 && m_kind[op] == 0 &&
            !(m_susp && (m_chip || int'(op_addr[19:15]) == m_sec));
      gs  = ok && op_kind == 2 && !m_act && m_kind[op] == 0;
      gc  = ok && op_kind == 3 && !m_act && m_kind[0] == 0 && m_kind[1] == 0;
      res = resume && m_susp &&
            (m_chip ? (m_kind[0] == 0 && m_kind[1] == 0) : (op == m_pl && m_kind[m_pl] == 0));
      for (int q = 0; q < 2; q++) begin
        tch = m_chip || m_pl == q;
        nk[q] = m_kind[q];
        nt6[q] = m_t6[q];
        if (f6 && rp == q) nt6[q] = ~m_t6[q];
        if (m_kind[q] != 0 && (done[q] || (m_chip && run && done != 0))) nk[q] = 0;
        else if (fire && tch) nk[q] = 0;
        else if (res && tch) nk[q] = 2;
        else if (gp && op == q) begin nk[q] = 1; m_pd[q] = poll_bit; nt6[q] = 0; end
        else if ((gs && op == q) || gc) begin nk[q] = 2; nt6[q] = 0; end
      end
      if (fire) m_t2 = 0; else if (f2) m_t2 = ~m_t2;
      if (edone) begin
        m_act = 0; m_pend = 0; m_susp = 0;
      end else begin
        bit pre_act, pre_susp, pre_pend;
        pre_act = m_act; pre_susp = m_susp; pre_pend = m_pend;
        if (gs || gc) begin m_act = 1; m_chip = gc; m_sec = int'(op_addr[19:15]); m_pl = op; end
        if (suspend && pre_act && !pre_susp && !pre_pend) begin m_pend = 1; m_cnt = S - 1; end
        else if (pre_pend) begin
          if (m_cnt == 0) begin m_pend = 0; m_susp = 1; end
          else m_cnt = m_cnt - 1;
        end
        if (res) m_susp = 0;
      end
      for (int q = 0; q < 2; q++) begin m_kind[q] = nk[q]; m_t6[q] = nt6[q]; end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit eb;
      eb = (m_kind[0] == 0 && m_kind[1] == 0);
      checks++;
      if (rdy_n !== eb || rd_data !== m_rd) begin
        errors++;
        $display("FAIL %s model: rdy=%b data=%h expected rdy=%b data=%h",
                 tag, rdy_n, rd_data, eb, m_rd);
      end
    end
  end

  task automatic cyc(input bit r, input logic [19:0] ra, input bit st, input logic [1:0] k,
                     input logic [19:0] oa, input bit pb, input bit su, input bit re,
                     input logic [1:0] dn);
    @(negedge clk); #1;
    rd = r; rd_addr = ra; op_start = st; op_kind = k; op_addr = oa;
    poll_bit = pb; suspend = su; resume = re; done = dn;
    @(posedge clk); #1;
    rd = 0; op_start = 0; op_kind = 0; suspend = 0; resume = 0; done = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, rd_addr, 0, 0, op_addr, 0, 0, 0, 2'b00);
  endtask
  task automatic rdx(input logic [19:0] a);       cyc(1, a, 0, 0, op_addr, 0, 0, 0, 2'b00); endtask
  task automatic start(input logic [1:0] k, input logic [19:0] a, input bit pb);
    cyc(0, rd_addr, 1, k, a, pb, 0, 0, 2'b00);
  endtask
  task automatic susp();                          cyc(0, rd_addr, 0, 0, op_addr, 0, 1, 0, 2'b00); endtask
  task automatic resm(input logic [19:0] a);      cyc(0, rd_addr, 0, 0, a, 0, 0, 1, 2'b00); endtask
  task automatic fin(input logic [1:0] m);        cyc(0, rd_addr, 0, 0, op_addr, 0, 0, 0, m); endtask

  task automatic exp_rd(input logic [15:0] e, input string t);
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s read: actual=%h expected=%h", t, rd_data, e);
    end
  endtask
  task automatic exp_rdy(input bit e, input string t);
    checks++;
    if (rdy_n !== e) begin
      errors++;
      $display("FAIL %s ready/busy: actual=%b expected=%b", t, rdy_n, e);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    tag = "R7"; exp_rdy(1, "R7"); exp_rd(16'h0000, "R7");
    // R1 idle planes
    tag = "R1";
    rdx(20'h01234); exp_rd(16'h48F7, "R1");
    rdx(20'h80000); exp_rd(16'h5AC3, "R1");
    // R3 R5 R2 program on plane 0
    tag = "R3";
    start(2'd1, 20'h01234, 1); exp_rdy(0, "R7");
    rdx(20'h01234); exp_rd(16'h0000, "R3");
    rdx(20'h01234); exp_rd(16'h0040, "R5");
    rdx(20'h80010); exp_rd(16'h5AD3, "R1");
    rdx(20'h01234); exp_rd(16'h0000, "R5");
    tag = "R6";
    fin(2'b01); exp_rdy(1, "R6");
    rdx(20'h01234); exp_rd(16'h48F7, "R6");
    // R4 erase on plane 1, R10 rejections
    tag = "R4";
    start(2'd2, 20'h88000, 0); exp_rdy(0, "R4");
    rdx(20'h88000); exp_rd(16'h0000, "R4");
    rdx(20'h88000); exp_rd(16'h0040, "R2");
    tag = "R10";
    start(2'd2, 20'h00000, 0);
    rdx(20'h00100); exp_rd(16'h5BC3, "R10");
    start(2'd1, 20'h80004, 0);
    rdx(20'h88000); exp_rd(16'h0000, "R10");
    // R8 suspend
    tag = "R8";
    susp(); idle(S - 1); exp_rdy(0, "R8");
    idle(1); exp_rdy(1, "R8");
    rdx(20'h80000); exp_rd(16'h5AC3, "R8");
    tag = "R9";
    rdx(20'h88010); exp_rd(16'h0080, "R9");
    rdx(20'h88010); exp_rd(16'h0084, "R9");
    start(2'd1, 20'h88004, 0); exp_rdy(1, "R9");
    tag = "R13";
    start(2'd1, 20'h80004, 0); exp_rdy(0, "R13");
    rdx(20'h88000); exp_rd(16'h0080, "R13");
    rdx(20'h80000); exp_rd(16'h00C0, "R13");
    rdx(20'h88000); exp_rd(16'h0084, "R13");
    fin(2'b10); exp_rdy(1, "R13");
    tag = "R10";
    start(2'd2, 20'h00000, 0); exp_rdy(1, "R10");
    tag = "R11";
    resm(20'h01234); exp_rdy(1, "R11");
    resm(20'h80000); exp_rdy(0, "R11");
    rdx(20'h88000); exp_rd(16'h0040, "R11");
    fin(2'b10); exp_rdy(1, "R6");
    rdx(20'h88000); exp_rd(16'hDAC3, "R6");
    // R12 whole-array erase
    tag = "R12";
    start(2'd3, 20'h00000, 0); exp_rdy(0, "R12");
    rdx(20'h01234); exp_rd(16'h0000, "R12");
    rdx(20'h80000); exp_rd(16'h0000, "R12");
    rdx(20'h01234); exp_rd(16'h0040, "R12");
    susp(); idle(S); exp_rdy(1, "R12");
    rdx(20'h01234); exp_rd(16'h0080, "R12");
    rdx(20'h80000); exp_rd(16'h0084, "R12");
    start(2'd1, 20'h40000, 0); exp_rdy(1, "R12");
    resm(20'h01234); exp_rdy(0, "R12");
    fin(2'b10); exp_rdy(1, "R12");
    rdx(20'h01234); exp_rd(16'h48F7, "R12");
    rdx(20'h80000); exp_rd(16'h5AC3, "R12");
    // R14 collisions
    tag = "R14";
    start(2'd1, 20'h01234, 1);
    cyc(1, 20'h01234, 0, 0, op_addr, 0, 0, 0, 2'b01);
    exp_rd(16'h0000, "R14"); exp_rdy(1, "R14");
    rdx(20'h01234); exp_rd(16'h48F7, "R14");
    start(2'd2, 20'h88000, 0);
    susp(); idle(S - 1); fin(2'b10); exp_rdy(1, "R14");
    rdx(20'h88000); exp_rd(16'hDAC3, "R14");
    start(2'd2, 20'h88000, 0); exp_rdy(0, "R14");
    fin(2'b10);
    // R8 suspend with nothing running
    tag = "R8";
    susp(); idle(S + 1);
    start(2'd2, 20'h80000, 0); idle(S + 2); exp_rdy(0, "R8");
    fin(2'b10); exp_rdy(1, "R8");
    idle(2);
    summary();
  end

endmodule